// File: doc/BRIEF.md
# Memory Bank Address Decoder

This block decides which of four logical memory banks in one controller claims an incoming physical address. Each bank owns a 64-bit decode register, loaded through a plain write port. The register carries an enable bit plus two compare fields. Each compare field has a match value and a don't-care mask. One field covers a wide upper slice of the address and the other covers a narrow lower slice that selects the interleave way.

On every address request the block compares the address against all four banks in parallel. One cycle later it returns a hit flag, the index of the winning bank, and a global bank identifier formed from the controller's port number and that index. A side query port reports the layout that follows from any one bank's register: the base address, the interleave factor and the bank size. All three are decoded from the mask fields rather than stored.

Top module: `mbd_decoder`

## Requirements
- R1: After reset every decode register is zero, so every bank is invalid. `rsp_valid`, `rsp_hit`, `rsp_bank` and `rsp_gid` are all zero, and a query of any bank reports base 0, interleave 16 and size 2^26/16.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored into the register of bank `wr_sel`. A request at that same edge still sees the old contents, and the next edge sees the new ones. The register layout is: bit 63 valid, [47:36] upper mask, [35:24] upper match, [15:12] lower mask, [11:8] lower match; all other bits are ignored.
- R3: A bank whose valid bit is clear never matches.
- R4: The upper field is address bits [37:26]. It matches when (upper XOR upper match) is zero at every position where the upper mask bit is 0.
- R5: The lower field is address bits [9:6]. It matches by the same rule, using the lower match and the lower mask. A bank hits only when it is valid and both fields match.
- R6: When several banks hit, the lowest-numbered one wins. When none hits, `rsp_hit` is 0 and `rsp_bank` and `rsp_gid` are 0.
- R7: On a hit, `rsp_gid` equals 4 × `port_id` + bank index, where `port_id` is sampled with the request.
- R8: `info_ilv` is decoded from the lower mask as follows: F→1, E→2, C→4, 8→8, 0→16, any other value→1.
- R9: `info_base` is (upper match AND NOT upper mask) shifted left by 26.
- R10: `info_size` is (upper mask bits [9:0] + 1) shifted left by 26, then divided by the interleave factor. Upper mask bits 10 and 11 do not affect the size.
- R11: A response appears exactly one cycle after `req_valid` is high at an edge. `rsp_valid` is 0 in any cycle that follows an edge without a request, and `rsp_hit` is 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Decode register write strobe |
| wr_sel | input | 2 | Bank whose register is written |
| wr_data | input | 64 | New decode register contents |
| port_id | input | 4 | Controller port number |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 40 | Physical address to decode |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Some bank claimed the address |
| rsp_bank | output | 2 | Index of the winning bank |
| rsp_gid | output | 6 | Global bank identifier |
| info_sel | input | 2 | Bank whose layout is reported |
| info_base | output | 40 | Base address of the selected bank |
| info_ilv | output | 5 | Interleave factor of the selected bank |
| info_size | output | 40 | Size of the selected bank |

## Verification
Lookup results (`rsp_valid`, `rsp_hit`, `rsp_bank` and `rsp_gid`) are registered. They are due one edge after the request edge, so the bench drives a request on a falling edge and reads the response on the next falling edge. It then reads once more a cycle later, to confirm that `rsp_valid` has dropped. The layout outputs are combinational from the stored registers and are due right after the write edge, so they are read on the falling edge that follows a write. A write and a request placed on the same edge check that the request still decodes against the old contents.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    localparam int NBANK      = 4;
    localparam int BANK_W     = $clog2(NBANK);
    localparam int REG_W      = 64;
    localparam int UW         = 12;
    localparam int LW         = 4;
    localparam int SIZE_BITS  = 10;
    localparam int ILV_W      = 5;
    localparam int ILV_LOG_W  = 3;

    localparam int VALID_BIT  = 63;
    localparam int UMASK_LSB  = 36;
    localparam int UMATCH_LSB = 24;
    localparam int LMASK_LSB  = 12;
    localparam int LMATCH_LSB = 8;

    typedef struct packed {
        logic          valid;
        logic [UW-1:0] umask;
        logic [UW-1:0] umatch;
        logic [LW-1:0] lmask;
        logic [LW-1:0] lmatch;
    } dec_fields_t;

    function automatic dec_fields_t unpack_reg(input logic [REG_W-1:0] r);
        dec_fields_t f;
        f.valid  = r[VALID_BIT];
        f.umask  = r[UMASK_LSB  +: UW];
        f.umatch = r[UMATCH_LSB +: UW];
        f.lmask  = r[LMASK_LSB  +: LW];
        f.lmatch = r[LMATCH_LSB +: LW];
        return f;
    endfunction

    // log2 of the interleave factor implied by the lower mask
    function automatic logic [ILV_LOG_W-1:0] ilv_log2(input logic [LW-1:0] m);
        logic [ILV_LOG_W-1:0] v;
        case (m)
            4'hF:    v = 3'd0;
            4'hE:    v = 3'd1;
            4'hC:    v = 3'd2;
            4'h8:    v = 3'd3;
            4'h0:    v = 3'd4;
            default: v = 3'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mbd_bank_match.sv
module mbd_bank_match
    import mbd_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int UPPER_SHIFT = 26,
    parameter int LOWER_SHIFT = 6
) (
    input  dec_fields_t       fields,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [UW-1:0] up_diff;
    logic [LW-1:0] lo_diff;

    always_comb begin
        // differences that fall outside the don't-care set disqualify
        up_diff = (addr[UPPER_SHIFT +: UW] ^ fields.umatch) & ~fields.umask;
        lo_diff = (addr[LOWER_SHIFT +: LW] ^ fields.lmatch) & ~fields.lmask;
        hit     = fields.valid && (up_diff == '0) && (lo_diff == '0);
    end
endmodule

// File: rtl/mbd_bank_geom.sv
module mbd_bank_geom
    import mbd_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int UPPER_SHIFT = 26
) (
    input  dec_fields_t       fields,
    output logic [ADDR_W-1:0] base,
    output logic [ILV_W-1:0]  ilv,
    output logic [ADDR_W-1:0] size
);
    logic [ILV_LOG_W-1:0] lg;
    logic [ADDR_W-1:0]    span;

    always_comb begin
        lg   = ilv_log2(fields.lmask);
        ilv  = ILV_W'(1) << lg;
        base = ADDR_W'(fields.umatch & ~fields.umask) << UPPER_SHIFT;
        span = (ADDR_W'(fields.umask[SIZE_BITS-1:0]) + ADDR_W'(1)) << UPPER_SHIFT;
        size = span >> lg;
    end
endmodule

// File: rtl/mbd_first_hit.sv
module mbd_first_hit #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/mbd_decoder.sv
module mbd_decoder
    import mbd_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int PORT_W      = 4,
    parameter int UPPER_SHIFT = 26,
    parameter int LOWER_SHIFT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [BANK_W-1:0]        wr_sel,
    input  logic [REG_W-1:0]         wr_data,
    input  logic [PORT_W-1:0]        port_id,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [BANK_W-1:0]        rsp_bank,
    output logic [PORT_W+BANK_W-1:0] rsp_gid,
    input  logic [BANK_W-1:0]        info_sel,
    output logic [ADDR_W-1:0]        info_base,
    output logic [ILV_W-1:0]         info_ilv,
    output logic [ADDR_W-1:0]        info_size
);
    localparam int GID_W = PORT_W + BANK_W;

    typedef struct packed {
        logic [NBANK-1:0][REG_W-1:0] regs;
        logic                        rsp_valid;
        logic                        rsp_hit;
        logic [BANK_W-1:0]           rsp_bank;
        logic [GID_W-1:0]            rsp_gid;
    } state_t;

    state_t state_d, state_q;

    dec_fields_t         fields   [NBANK];
    logic [NBANK-1:0]    match_vec;
    logic [NBANK-1:0]    valid_vec;
    logic                any_hit;
    logic [BANK_W-1:0]   win_idx;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign fields[b]    = unpack_reg(state_q.regs[b]);
        assign valid_vec[b] = fields[b].valid;

        mbd_bank_match #(
            .ADDR_W      (ADDR_W),
            .UPPER_SHIFT (UPPER_SHIFT),
            .LOWER_SHIFT (LOWER_SHIFT)
        ) u_match (
            .fields (fields[b]),
            .addr   (req_addr),
            .hit    (match_vec[b])
        );
    end

    mbd_first_hit #(
        .N     (NBANK),
        .IDX_W (BANK_W)
    ) u_pick (
        .req (match_vec),
        .any (any_hit),
        .idx (win_idx)
    );

    mbd_bank_geom #(
        .ADDR_W      (ADDR_W),
        .UPPER_SHIFT (UPPER_SHIFT)
    ) u_geom (
        .fields (fields[info_sel]),
        .base   (info_base),
        .ilv    (info_ilv),
        .size   (info_size)
    );

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = req_valid;
        state_d.rsp_hit   = 1'b0;
        state_d.rsp_bank  = '0;
        state_d.rsp_gid   = '0;
        if (req_valid && any_hit) begin
            state_d.rsp_hit  = 1'b1;
            state_d.rsp_bank = win_idx;
            state_d.rsp_gid  = {port_id, win_idx};
        end
        if (wr_en) begin
            state_d.regs[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_hit   = state_q.rsp_hit;
    assign rsp_bank  = state_q.rsp_bank;
    assign rsp_gid   = state_q.rsp_gid;

    // R11: no request at an edge means no response after it
    a_r11_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R11: a hit is only reported alongside a response
    a_r11_hit_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R3: the reported bank was enabled when the request was compared
    a_r3_valid_bank: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ((($past(valid_vec) >> rsp_bank) & NBANK'(1)) != '0));

    // R6: no lower-numbered bank also matched
    a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (($past(match_vec) & ((NBANK'(1) << rsp_bank) - NBANK'(1))) == '0));

    // R6: a miss means no bank matched
    a_r6_clean_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> ($past(match_vec) == '0));

    // R7: identifier combines the sampled port with the bank index
    a_r7_gid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_gid == {$past(port_id), rsp_bank}));
endmodule

// File: tb/sim_mbd_decoder.sv
module sim_mbd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [3:0]  port_id = 4'd5;
    logic        req_valid = 1'b0;
    logic [39:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_bank;
    logic [5:0]  rsp_gid;
    logic [1:0]  info_sel = '0;
    logic [39:0] info_base, info_size;
    logic [4:0]  info_ilv;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mbd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .port_id(port_id), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_bank(rsp_bank), .rsp_gid(rsp_gid), .info_sel(info_sel),
        .info_base(info_base), .info_ilv(info_ilv), .info_size(info_size)
    );

    function automatic logic [63:0] enc(input logic v, input logic [11:0] um,
        input logic [11:0] uv, input logic [3:0] lm, input logic [3:0] lv);
        return {v, 15'd0, um, uv, 8'd0, lm, lv, 8'd0};
    endfunction

    function automatic logic [39:0] mk_addr(input logic [11:0] up, input logic [3:0] lo);
        return (40'(up) << 26) | (40'(lo) << 6);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [39:0] a);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_geom(input string tag, input logic [1:0] sel,
        input logic [39:0] b, input logic [4:0] ilv, input logic [39:0] sz);
        info_sel = sel;
        #1;
        chk({tag, " base"}, 64'(info_base), 64'(b));
        chk({tag, " ilv"},  64'(info_ilv),  64'(ilv));
        chk({tag, " size"}, 64'(info_size), 64'(sz));
    endtask

    localparam int NV = 10;
    localparam logic [11:0] V_UP  [NV] = '{12'h101, 12'h105, 12'h002, 12'h003, 12'h003,
                                           12'h004, 12'h010, 12'h1FF, 12'h0FF, 12'h902};
    localparam logic [3:0]  V_LO  [NV] = '{4'h5, 4'h0, 4'h2, 4'h6, 4'h3,
                                           4'h2, 4'h0, 4'h0, 4'h0, 4'h2};
    localparam logic        V_HIT [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
                                           1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [1:0]  V_BNK [NV] = '{2'd0, 2'd3, 2'd1, 2'd1, 2'd0,
                                           2'd0, 2'd0, 2'd3, 2'd0, 2'd0};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        chk("R1 rsp_hit", 64'(rsp_hit), 0);
        chk("R1 rsp_gid", 64'(rsp_gid), 0);
        chk_geom("R1 bank0", 2'd0, 40'd0, 5'd16, 40'h400000);
        rst_n = 1'b1;
        @(negedge clk);
        lookup(mk_addr(12'h000, 4'h0));
        chk("R1 R3 invalid after reset", 64'(rsp_hit), 0);

        // R2: configure banks
        wr(2'd0, enc(1'b1, 12'h000, 12'h101, 4'hF, 4'h0));
        wr(2'd1, enc(1'b1, 12'h001, 12'h002, 4'hC, 4'h2));
        wr(2'd2, enc(1'b0, 12'h000, 12'h010, 4'hF, 4'h0));
        wr(2'd3, enc(1'b1, 12'h0FF, 12'h100, 4'hF, 4'h0));

        // R3 R4 R5 R6 R7 R11: vector table
        for (int i = 0; i < NV; i++) begin
            lookup(mk_addr(V_UP[i], V_LO[i]));
            chk($sformatf("R11 vec%0d valid", i), 64'(rsp_valid), 1);
            chk($sformatf("R4 R5 vec%0d hit", i), 64'(rsp_hit), 64'(V_HIT[i]));
            chk($sformatf("R6 vec%0d bank", i), 64'(rsp_bank), V_HIT[i] ? 64'(V_BNK[i]) : 0);
            chk($sformatf("R7 vec%0d gid", i), 64'(rsp_gid),
                V_HIT[i] ? 64'(5 * 4 + V_BNK[i]) : 0);
        end
        @(negedge clk);
        chk("R11 valid drops", 64'(rsp_valid), 0);
        chk("R11 hit drops", 64'(rsp_hit), 0);

        // R7: other port ids
        port_id = 4'hF;
        lookup(mk_addr(12'h002, 4'hA));
        chk("R7 port15 gid", 64'(rsp_gid), 61);
        port_id = 4'd0;
        lookup(mk_addr(12'h150, 4'h0));
        chk("R7 port0 gid", 64'(rsp_gid), 3);
        port_id = 4'd5;

        // R9 R10 R8: geometry
        chk_geom("R9 R10 bank1", 2'd1, 40'h8000000, 5'd4, 40'h2000000);
        chk_geom("R9 R10 bank3", 2'd3, 40'h400000000, 5'd1, 40'h400000000);
        wr(2'd2, enc(1'b0, 12'hC03, 12'hFFF, 4'h0, 4'h0));
        chk_geom("R10 R8 high mask bits", 2'd2, 40'hFF0000000, 5'd16, 40'h1000000);
        wr(2'd2, enc(1'b0, 12'h003, 12'h000, 4'hE, 4'h0));
        chk_geom("R8 mask E", 2'd2, 40'd0, 5'd2, 40'h8000000);
        wr(2'd2, enc(1'b0, 12'h003, 12'h000, 4'h8, 4'h0));
        chk_geom("R8 mask 8", 2'd2, 40'd0, 5'd8, 40'h2000000);
        wr(2'd2, enc(1'b0, 12'h003, 12'h000, 4'h5, 4'h0));
        chk_geom("R8 mask other", 2'd2, 40'd0, 5'd1, 40'h10000000);

        // R2: write and request on the same edge uses old contents
        wr(2'd2, enc(1'b0, 12'h000, 12'h010, 4'hF, 4'h0));
        req_valid = 1'b1; req_addr = mk_addr(12'h010, 4'h0);
        wr_en = 1'b1; wr_sel = 2'd2; wr_data = enc(1'b1, 12'h000, 12'h010, 4'hF, 4'h0);
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        chk("R2 same-edge old", 64'(rsp_hit), 0);
        lookup(mk_addr(12'h010, 4'h0));
        chk("R2 next-edge new hit", 64'(rsp_hit), 1);
        chk("R2 next-edge new bank", 64'(rsp_bank), 2);
        // R2: ignored bits have no effect
        wr(2'd2, enc(1'b1, 12'h000, 12'h010, 4'hF, 4'h0) | 64'h7FFF_0000_00FF_00FF);
        lookup(mk_addr(12'h010, 4'h0));
        chk("R2 ignored bits hit", 64'(rsp_hit), 1);
        chk_geom("R2 ignored bits", 2'd2, 40'h40000000, 5'd1, 40'h4000000);

        // R1: reset mid-run clears registers
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_geom("R1 bank1 cleared", 2'd1, 40'd0, 5'd16, 40'h400000);
        lookup(mk_addr(12'h002, 4'h2));
        chk("R1 no hit after reset", 64'(rsp_hit), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule